// File: doc/BRIEF.md
# Parallel Port to Serial Link Bridge

This block connects a host that speaks through an 8-bit parallel port with two strobe lines to an asynchronous serial line using 8 data bits, no parity and one stop bit. A three-state direction register chooses between idle, receiving (serial to parallel) and sending (parallel to serial). The host changes direction, and moves data, by toggling a read strobe or a write strobe. A single status output tells the host when a byte is waiting or when the transmitter is ready for more.

In receive direction, each byte that arrives on the serial input joins a circular queue, and the oldest unread byte is held on the parallel output. Each acting read strobe retires that byte and shows the next one. In send direction, the parallel output is released, and each acting write strobe captures the parallel input and sends it as one serial frame. Every strobe input counts level changes and acts only on alternate ones. The first acting strobe in a new direction only switches direction and moves no data.

The bit rate comes from dividing the system clock (`CLK_HZ / BAUD` cycles per bit, 16 ticks per bit). Both strobes and the serial input are resynchronised with two flops before any edge is detected.

Top module: `pbus_uart_bridge`

## Requirements
- R1: After reset the direction is idle, status is 0, `bus_oe` is 0, `bus_out` is 0x00 and `uart_txd` is 1.
- R2: On each strobe line, the 1st, 3rd, 5th, ... level changes act and the 2nd, 4th, ... changes leave every output unchanged.
- R3: An acting read strobe outside receive direction enters receive direction, sets `bus_oe` to 1, empties the queue and drives status to 0. It consumes no byte.
- R4: An acting read strobe in receive direction with a non-empty queue retires the oldest byte. If the queue is then empty, status goes to 0 and `bus_out` keeps its value; otherwise `bus_out` shows the new oldest byte. With an empty queue the strobe has no effect.
- R5: A byte received in receive direction is appended to the queue. `bus_out` then shows the oldest queued byte and status goes to 1.
- R6: A byte that arrives while the queue already holds `QDEPTH` bytes empties the queue first and becomes its only entry.
- R7: Bytes received outside receive direction are discarded: status and `bus_out` do not change.
- R8: An acting write strobe outside send direction sets `bus_out` to 0x00 when leaving receive direction, sets `bus_oe` to 0, enters send direction and drives status to 1. No frame is sent.
- R9: An acting write strobe in send direction captures `bus_in` and drives status to 0. The byte is sent when the transmitter is free, as a frame of one 0 start bit, 8 data bits LSB first and one 1 stop bit, each `CLK_HZ/BAUD` cycles long.
- R10: When a frame finishes while in send direction, status returns to 1.
- R11: The receiver accepts a start bit only if the line is still low at its midpoint and samples each data bit at mid-bit. A frame whose stop bit is 0 is discarded, and reception resumes only after the line returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_stb | input | 1 | Read strobe; level changes counted |
| wr_stb | input | 1 | Write strobe; level changes counted |
| bus_in | input | 8 | Parallel data from host (send direction) |
| bus_out | output | 8 | Parallel data to host (receive direction) |
| bus_oe | output | 1 | High while the block drives the parallel bus |
| status | output | 1 | Byte available / transmitter ready |
| uart_rxd | input | 1 | Serial input, idle high |
| uart_txd | output | 1 | Serial output, idle high |

## Verification
A strobe level change passes two synchroniser flops and one edge-compare flop, so its effect reaches `status`, `bus_oe` and `bus_out` three clock edges after the change. The bench waits eight cycles before sampling. A received byte is taken at the middle of its stop bit, and its effect appears about three cycles later, so the bench samples only after the whole frame plus forty idle cycles. A sent frame starts a few cycles after the acting write strobe. The bench polls for the falling start edge, then samples each bit half a bit period after its edge, which leaves several cycles of slack against the tick-grid phase. All inputs are driven, and all outputs sampled, on the falling clock edge.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
   typedef enum logic [1:0] {
      MODE_IDLE = 2'd0,
      MODE_RD   = 2'd1,
      MODE_WR   = 2'd2
   } bmode_t;
endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bridge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {STAGES{RST_VAL}};
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/bridge_rxq.sv
module bridge_rxq #(
   parameter int W     = 8,
   parameter int DEPTH = 100,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  head_q,
   output logic [W-1:0]  next_q,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("bridge_rxq: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] head, head_inc, tail;
   logic [CW-1:0] cnt;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign head_inc = head + 1'b1;
         assign tail     = head + cnt[AW-1:0];
      end else begin : g_mod
         logic [AW:0] sum;
         assign sum      = {1'b0, head} + (AW+1)'(cnt);
         assign tail     = (sum >= (AW+1)'(DEPTH)) ? AW'(sum - (AW+1)'(DEPTH)) : sum[AW-1:0];
         assign head_inc = (head == AW'(DEPTH - 1)) ? '0 : head + 1'b1;
      end
   endgenerate

   assign full   = (cnt == CW'(DEPTH));
   assign empty  = (cnt == '0);
   assign count  = cnt;
   assign head_q = mem[head];
   assign next_q = mem[head_inc];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head <= '0;
         cnt  <= '0;
      end else if (clr) begin
         head <= '0;
         cnt  <= '0;
      end else if (push && full) begin
         head <= '0;
         cnt  <= CW'(1);
      end else if (push) begin
         cnt  <= cnt + 1'b1;
      end else if (pop && !empty) begin
         head <= head_inc;
         cnt  <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!clr && push) begin
         if (full) mem[0]    <= din;
         else      mem[tail] <= din;
      end
   end

   // R6: operations are exclusive, overflow restarts at one entry
   p_ops_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({clr, push, pop}));
   p_flush_on_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !clr) |=> (count == CW'(1)));
   p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R4: the head is only retired when something is queued
   p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/bridge_uart_rx.sv
module bridge_uart_rx #(
   parameter int OVS = 16,
   localparam int OW = $clog2(OVS)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxd,
   output logic       valid,
   output logic [7:0] data
);
   generate
      if (OVS < 4 || (1 << OW) != OVS) begin : g_bad_ovs
         $error("bridge_uart_rx: OVS must be a power of two, at least 4");
      end
   endgenerate

   typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_WAIT} rxst_t;
   rxst_t         st;
   logic [OW-1:0] cnt;
   logic [2:0]    bitn;
   logic [7:0]    sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         sh    <= '0;
         valid <= 1'b0;
         data  <= '0;
      end else begin
         valid <= 1'b0;
         unique case (st)
            S_IDLE: if (!rxd) begin
               st  <= S_START;
               cnt <= '0;
            end
            S_START: if (tick) begin
               if (cnt == OW'(OVS/2 - 1)) begin
                  cnt  <= '0;
                  bitn <= '0;
                  st   <= rxd ? S_IDLE : S_DATA;
               end else cnt <= cnt + 1'b1;
            end
            S_DATA: if (tick) begin
               cnt <= cnt + 1'b1;
               if (cnt == OW'(OVS - 1)) begin
                  sh   <= {rxd, sh[7:1]};
                  bitn <= bitn + 1'b1;
                  if (bitn == 3'd7) st <= S_STOP;
               end
            end
            S_STOP: if (tick) begin
               cnt <= cnt + 1'b1;
               if (cnt == OW'(OVS - 1)) begin
                  if (rxd) begin
                     valid <= 1'b1;
                     data  <= sh;
                     st    <= S_IDLE;
                  end else st <= S_WAIT;
               end
            end
            S_WAIT: if (rxd) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   // R11: a delivered byte is a single-cycle pulse
   p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   // R11: no byte is delivered from a frame with a low stop bit
   p_badstop_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WAIT) |=> !valid);
endmodule

// File: rtl/bridge_uart_tx.sv
module bridge_uart_tx #(
   parameter int OVS = 16,
   localparam int OW = $clog2(OVS)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       start,
   input  logic [7:0] data,
   output logic       busy,
   output logic       done,
   output logic       txd
);
   logic [9:0]    sh;
   logic [3:0]    bitc;
   logic [OW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         bitc <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               sh   <= {1'b1, data, 1'b0};
               bitc <= '0;
               cnt  <= '0;
               busy <= 1'b1;
            end
         end else if (tick) begin
            cnt <= cnt + 1'b1;
            if (cnt == OW'(OVS - 1)) begin
               sh <= {1'b1, sh[9:1]};
               if (bitc == 4'd9) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else bitc <= bitc + 1'b1;
            end
         end
      end
   end

   assign txd = busy ? sh[0] : 1'b1;

   // R9: every frame opens with a low start bit
   p_start_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd);
   // R10: completion follows the end of a frame
   p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));
endmodule

// File: rtl/pbus_uart_bridge.sv
module pbus_uart_bridge
   import bridge_pkg::*;
#(
   parameter int CLK_HZ = 16_000_000,
   parameter int BAUD   = 9600,
   parameter int OVS    = 16,
   parameter int QDEPTH = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_stb,
   input  logic       wr_stb,
   input  logic [7:0] bus_in,
   output logic [7:0] bus_out,
   output logic       bus_oe,
   output logic       status,
   input  logic       uart_rxd,
   output logic       uart_txd
);
   localparam int DIV = CLK_HZ / (BAUD * OVS);
   localparam int BW  = (DIV > 1) ? $clog2(DIV) : 1;
   localparam int QCW = $clog2(QDEPTH + 1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("pbus_uart_bridge: CLK_HZ too low for BAUD*OVS");
      end
   endgenerate

   // baud tick at OVS times the bit rate
   logic [BW-1:0] bcnt;
   logic          tick;
   assign tick = (bcnt == BW'(DIV - 1));
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bcnt <= '0;
      else if (tick) bcnt <= '0;
      else           bcnt <= bcnt + 1'b1;
   end

   // synchronisers
   logic rd_s, wr_s, rx_s;
   bridge_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rd_sync (.clk, .rst_n, .d(rd_stb),   .q(rd_s));
   bridge_sync #(.STAGES(2), .RST_VAL(1'b0)) u_wr_sync (.clk, .rst_n, .d(wr_stb),   .q(wr_s));
   bridge_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rx_sync (.clk, .rst_n, .d(uart_rxd), .q(rx_s));

   // strobe edges, alternate edges act
   logic rd_d, wr_d, rd_flag, wr_flag;
   logic rd_act, wr_act;
   assign rd_act = (rd_s ^ rd_d) & ~rd_flag;
   assign wr_act = (wr_s ^ wr_d) & ~wr_flag;

   // serial engines
   logic       rx_v, tx_busy, tx_done, tx_go;
   logic [7:0] rx_d;
   logic [7:0] hold_q;
   logic       hold_full;
   assign tx_go = hold_full & ~tx_busy;

   bridge_uart_rx #(.OVS(OVS)) u_rx (
      .clk, .rst_n, .tick, .rxd(rx_s), .valid(rx_v), .data(rx_d));
   bridge_uart_tx #(.OVS(OVS)) u_tx (
      .clk, .rst_n, .tick, .start(tx_go), .data(hold_q),
      .busy(tx_busy), .done(tx_done), .txd(uart_txd));

   // receive queue
   logic            q_clr, q_push, q_pop, q_full, q_empty;
   logic [7:0]      q_head, q_next;
   logic [QCW-1:0]  q_count;
   logic [7:0]      rx_byte;
   logic            rx_pend, txd_pend;
   bmode_t          mode;
   logic            rx_serve, txd_serve;

   assign rx_serve  = !wr_act && !rd_act && rx_pend;
   assign txd_serve = !wr_act && !rd_act && !rx_pend && txd_pend;

   always_comb begin
      q_clr  = 1'b0;
      q_pop  = 1'b0;
      q_push = 1'b0;
      if (wr_act) begin
         q_clr = 1'b0;
      end else if (rd_act) begin
         if (mode != MODE_RD) q_clr = 1'b1;
         else if (!q_empty)   q_pop = 1'b1;
      end else if (rx_pend && mode == MODE_RD) begin
         q_push = 1'b1;
      end
   end

   bridge_rxq #(.W(8), .DEPTH(QDEPTH)) u_q (
      .clk, .rst_n, .clr(q_clr), .push(q_push), .pop(q_pop), .din(rx_byte),
      .head_q(q_head), .next_q(q_next), .count(q_count),
      .full(q_full), .empty(q_empty));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_d      <= 1'b0;
         wr_d      <= 1'b0;
         rd_flag   <= 1'b0;
         wr_flag   <= 1'b0;
         mode      <= MODE_IDLE;
         status    <= 1'b0;
         bus_out   <= '0;
         hold_q    <= '0;
         hold_full <= 1'b0;
         rx_pend   <= 1'b0;
         rx_byte   <= '0;
         txd_pend  <= 1'b0;
      end else begin
         rd_d <= rd_s;
         wr_d <= wr_s;
         if (rd_s ^ rd_d) rd_flag <= ~rd_flag;
         if (wr_s ^ wr_d) wr_flag <= ~wr_flag;
         if (tx_go) hold_full <= 1'b0;

         if (wr_act) begin
            if (mode != MODE_WR) begin
               if (mode == MODE_RD) bus_out <= '0;
               mode   <= MODE_WR;
               status <= 1'b1;
            end else begin
               hold_q    <= bus_in;
               hold_full <= 1'b1;
               status    <= 1'b0;
            end
         end else if (rd_act) begin
            if (mode != MODE_RD) begin
               mode   <= MODE_RD;
               status <= 1'b0;
            end else if (!q_empty) begin
               if (q_count == QCW'(1)) status  <= 1'b0;
               else                    bus_out <= q_next;
            end
         end else if (rx_pend) begin
            rx_pend <= 1'b0;
            if (mode == MODE_RD) begin
               bus_out <= (q_empty || q_full) ? rx_byte : q_head;
               status  <= 1'b1;
            end
         end else if (txd_pend) begin
            txd_pend <= 1'b0;
            if (mode == MODE_WR) status <= 1'b1;
         end

         if (rx_v) begin
            rx_pend <= 1'b1;
            rx_byte <= rx_d;
         end
         if (tx_done) txd_pend <= 1'b1;
      end
   end

   assign bus_oe = (mode == MODE_RD);

   // R2: direction only moves on an acting strobe
   p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_act || wr_act) |=> $stable(mode));
   // R5, R8, R10: status rises only through a received byte, write entry or frame end
   p_status_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status) |-> $past(rx_serve || txd_serve || wr_act));
   // R7: bytes outside receive direction never enter the queue
   p_no_push_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MODE_RD) |-> !q_push);
   // R3: entering receive direction leaves an empty queue and low status
   p_read_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && !wr_act && mode != MODE_RD) |=> (q_empty && !status && bus_oe));
endmodule

// File: tb/sim_pbus_uart_bridge.sv
module sim_pbus_uart_bridge;
   localparam int BAUD   = 9600;
   localparam int OVS    = 16;
   localparam int CLK_HZ = BAUD * OVS * 4;
   localparam int QD     = 4;
   localparam int BIT    = CLK_HZ / BAUD;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_stb = 1'b0, wr_stb = 1'b0, uart_rxd = 1'b1;
   logic [7:0] bus_in = '0;
   logic [7:0] bus_out;
   logic       bus_oe, status, uart_txd;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   always #4 clk = ~clk;

   pbus_uart_bridge #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(OVS), .QDEPTH(QD)) u0 (
      .clk, .rst_n, .rd_stb, .wr_stb, .bus_in, .bus_out, .bus_oe, .status,
      .uart_rxd, .uart_txd);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic rd_tog();
      @(negedge clk) rd_stb = ~rd_stb;
      repeat (8) @(negedge clk);
   endtask

   task automatic wr_tog();
      @(negedge clk) wr_stb = ~wr_stb;
      repeat (8) @(negedge clk);
   endtask

   task automatic ser_send(input logic [7:0] b, input logic stop);
      @(negedge clk) uart_rxd = 1'b0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         uart_rxd = b[i];
         repeat (BIT) @(negedge clk);
      end
      uart_rxd = stop;
      repeat (BIT) @(negedge clk);
      uart_rxd = 1'b1;
      repeat (40) @(negedge clk);
   endtask

   // capture one frame from uart_txd; checks status low mid start bit
   task automatic capture(input logic [7:0] exp);
      logic [7:0] got = '0;
      int n = 0;
      while (uart_txd && n < 400) begin
         @(negedge clk);
         n++;
      end
      chk_eq("R9 start edge", int'(uart_txd), 0);
      repeat (BIT/2) @(negedge clk);
      chk_eq("R9 start bit", int'(uart_txd), 0);
      chk_eq("R9 status low while sending", int'(status), 0);
      for (int i = 0; i < 8; i++) begin
         repeat (BIT) @(negedge clk);
         got[i] = uart_txd;
      end
      chk_eq("R9 data byte", int'(got), int'(exp));
      repeat (BIT) @(negedge clk);
      chk_eq("R9 stop bit", int'(uart_txd), 1);
      repeat (BIT/2 + 16) @(negedge clk);
      chk_eq("R10 status after frame", int'(status), 1);
   endtask

   task automatic t_reset();
      chk_eq("R1 status", int'(status), 0);
      chk_eq("R1 bus_oe", int'(bus_oe), 0);
      chk_eq("R1 bus_out", int'(bus_out), 0);
      chk_eq("R1 txd idle", int'(uart_txd), 1);
   endtask

   task automatic t_idle_discard();
      ser_send(8'h5A, 1'b1);
      chk_eq("R7 idle status", int'(status), 0);
      chk_eq("R7 idle bus", int'(bus_out), 0);
   endtask

   task automatic t_read_flow();
      rd_tog();                                     // acts: enter receive
      chk_eq("R3 oe", int'(bus_oe), 1);
      chk_eq("R3 status", int'(status), 0);
      rd_tog();                                     // second change: skipped
      chk_eq("R2 skip oe", int'(bus_oe), 1);
      ser_send(8'h11, 1'b1);
      ser_send(8'h22, 1'b1);
      ser_send(8'h33, 1'b1);
      chk_eq("R5 head shown", int'(bus_out), 'h11);
      chk_eq("R5 status", int'(status), 1);
      rd_tog();                                     // acts: retire 11
      chk_eq("R4 next byte", int'(bus_out), 'h22);
      rd_tog();                                     // skipped
      chk_eq("R2 skip keeps bus", int'(bus_out), 'h22);
      rd_tog();                                     // acts: retire 22
      chk_eq("R4 next byte 2", int'(bus_out), 'h33);
      rd_tog();                                     // skipped
      rd_tog();                                     // acts: retire 33, empty
      chk_eq("R4 empty status", int'(status), 0);
      chk_eq("R4 bus kept", int'(bus_out), 'h33);
      rd_tog();                                     // skipped
      rd_tog();                                     // acts on empty queue
      chk_eq("R4 empty no effect status", int'(status), 0);
      chk_eq("R4 empty no effect bus", int'(bus_out), 'h33);
      rd_tog();                                     // skipped
   endtask

   task automatic t_overflow();
      for (int i = 0; i < QD; i++) ser_send(8'hA0 + 8'(i), 1'b1);
      chk_eq("R5 full head", int'(bus_out), 'hA0);
      ser_send(8'hA0 + 8'(QD), 1'b1);
      chk_eq("R6 new only entry", int'(bus_out), 'hA0 + QD);
      chk_eq("R6 status", int'(status), 1);
      rd_tog();                                     // acts: retire single entry
      chk_eq("R6 queue held one", int'(status), 0);
      rd_tog();                                     // skipped
      ser_send(8'hB1, 1'b1);                        // left queued
      chk_eq("R5 refill", int'(bus_out), 'hB1);
   endtask

   task automatic t_write_entry();
      int lows = 0;
      wr_tog();                                     // acts: enter send
      chk_eq("R8 oe", int'(bus_oe), 0);
      chk_eq("R8 bus zeroed", int'(bus_out), 0);
      chk_eq("R8 status", int'(status), 1);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (!uart_txd) lows++;
      end
      chk_eq("R8 no frame", lows, 0);
   endtask

   task automatic t_write_send();
      bus_in = 8'hC5;
      wr_tog();                                     // skipped
      chk_eq("R2 write skip status", int'(status), 1);
      chk_eq("R2 write skip txd", int'(uart_txd), 1);
      @(negedge clk) wr_stb = ~wr_stb;              // acts: send C5
      capture(8'hC5);
      bus_in = 8'h3C;
      wr_tog();                                     // skipped
      @(negedge clk) wr_stb = ~wr_stb;              // acts: send 3C
      capture(8'h3C);
   endtask

   task automatic t_write_discard();
      ser_send(8'h5E, 1'b1);
      chk_eq("R7 write status", int'(status), 1);
      chk_eq("R7 write bus", int'(bus_out), 0);
   endtask

   task automatic t_reentry();
      rd_tog();                                     // acts: enter receive, flush B1
      chk_eq("R3 reentry oe", int'(bus_oe), 1);
      chk_eq("R3 reentry status", int'(status), 0);
      ser_send(8'h77, 1'b1);
      chk_eq("R3 flushed old byte", int'(bus_out), 'h77);
   endtask

   task automatic t_bad_stop();
      rd_tog();                                     // skipped
      ser_send(8'h99, 1'b0);
      chk_eq("R11 bad frame bus", int'(bus_out), 'h77);
      rd_tog();                                     // acts: retire 77
      chk_eq("R11 bad frame not queued", int'(status), 0);
      ser_send(8'h42, 1'b1);
      chk_eq("R11 recovers", int'(bus_out), 'h42);
      chk_eq("R11 status", int'(status), 1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_idle_discard();
      t_read_flow();
      t_overflow();
      t_write_entry();
      t_write_send();
      t_write_discard();
      t_reentry();
      t_bad_stop();
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule